// File: doc/BRIEF.md
# Four-Core Interrupt Steering Unit

This unit steers interrupt requests to four processor cores. Each core has a normal-priority request output and a fast request output. Each core has its own four timer lines and its own four mailbox-pending lines. Three sources are shared by all cores: an upstream normal request, an upstream fast request and a local-timer interrupt. The block does not store mailbox contents and does not count time for the local timer. These arrive as level inputs, and the timer's enable and pending flags arrive as two separate levels.

Each core has one control byte for its timer lines and one for its mailbox lines. For each local source, the control byte gives one enable bit for normal delivery and one for fast delivery. When both are set, the source goes to the fast output only. Small routing fields pick the core that receives each shared source. For the local timer, the routing field also picks the request type. The result is kept in two 12-bit source words per core, one for normal requests and one for fast requests. A core output is asserted while its word has any bit set. Software reads the words and writes the configuration through a simple 32-bit word-addressed register port. That port has a write strobe and a combinational read path.

Top module: `irq_router`

## Requirements
- R1: After reset, every control byte and routing field reads zero and every source word reads zero. All core outputs are low, so every local source is masked and both upstream routes point to core 0.
- R2: Control byte at 0x40+4c steers timer line n of core c (n=0..3, line bit 4c+n of `tmr_lvl`). Bit n+4 set puts the line into bit n of the fast word. Bit n set with bit n+4 clear puts it into bit n of the normal word. With both bits clear the line is masked.
- R3: Control byte at 0x50+4c steers mailbox line n of core c (bit 4c+n of `mbx_lvl`) with the same bit meanings as R2. The result lands in bit 4+n of the words.
- R4: Register 0x0C bits 1:0 name the core whose normal word shows `up_irq` at bit 8. Bits 3:2 name the core whose fast word shows `up_fiq` at bit 8. A read returns the same layout.
- R5: Register 0x24 keeps 3 bits. Bits 1:0 pick a core, and bit 2 set selects the fast word while bit 2 clear selects the normal word. Bit 11 of the selected word is set only while both `lt_ie` and `lt_pend` are high.
- R6: A write to a control byte keeps only data bits 7:0. A write to 0x0C keeps bits 3:0. A write to 0x24 keeps bits 2:0.
- R7: `core_irq[c]` is high exactly when the normal word of core c is nonzero, and `core_fiq[c]` is high exactly when the fast word is nonzero. Bits 9 and 10 of every word are always zero.
- R8: A source word, and the two outputs that depend on it, reflect input levels sampled at the latest rising clock edge. They are combined with the configuration that held before that edge, so a register write changes the outputs one edge after it is accepted. The outputs are levels and do not latch.
- R9: Unknown offsets and misaligned addresses (bits 1:0 not zero) read zero, and writes to them change nothing. Writes to the source-word offsets change nothing either.
- R10: The normal word of core c reads at 0x60+4c and the fast word at 0x70+4c, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tmr_lvl | input | 16 | Timer lines, bits 4c+3..4c belong to core c |
| mbx_lvl | input | 16 | Mailbox-pending lines, bits 4c+3..4c belong to core c |
| up_irq | input | 1 | Shared upstream normal request |
| up_fiq | input | 1 | Shared upstream fast request |
| lt_ie | input | 1 | Local-timer interrupt enable level |
| lt_pend | input | 1 | Local-timer pending level |
| core_irq | output | 4 | Normal request to each core |
| core_fiq | output | 4 | Fast request to each core |

## Verification
The state that can go wrong here is a control byte, a routing field or a source-word bit. A control byte that is corrupted or written with the wrong mask changes which output a local line reaches. That shows on the core outputs at the first edge after the line rises. A misdirected routing field raises the wrong core's output within one cycle of the shared source going high. A stale source bit keeps an output high one cycle after every input has dropped. The reference model is compared at every clock and on every read, so each of these faults is seen in the cycle where it first has an effect.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int NUM_CORES = 4;
    localparam int CORE_W    = $clog2(NUM_CORES);
    localparam int LOCAL_N   = 4;
    localparam int CTRL_W    = 2 * LOCAL_N;
    localparam int SRC_W     = 12;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    // source bit positions inside a status word
    localparam int BIT_TMR0   = 0;
    localparam int BIT_MBX0   = 4;
    localparam int BIT_UP     = 8;
    localparam int BIT_PERF   = 9;
    localparam int BIT_BUSCNT = 10;
    localparam int BIT_LT     = 11;

    // register map: single registers by full address, banks by address[7:4]
    localparam logic [ADDR_W-1:0] OFS_UP_ROUTE = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LT_ROUTE = 8'h24;
    localparam logic [3:0] BANK_TMR = 4'h4;
    localparam logic [3:0] BANK_MBX = 4'h5;
    localparam logic [3:0] BANK_IRQ = 4'h6;
    localparam logic [3:0] BANK_FIQ = 4'h7;

    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [SRC_W-1:0]  srcw_t;

    typedef struct packed {
        logic [CORE_W-1:0]           up_fiq_core;
        logic [CORE_W-1:0]           up_irq_core;
        logic                        lt_as_fiq;
        logic [CORE_W-1:0]           lt_core;
        ctrl_t [NUM_CORES-1:0]       tmr_ctl;
        ctrl_t [NUM_CORES-1:0]       mbx_ctl;
    } cfg_t;

    typedef struct packed {
        srcw_t [NUM_CORES-1:0] irq_w;
        srcw_t [NUM_CORES-1:0] fiq_w;
    } stat_t;
endpackage

// File: rtl/irq_local_steer.sv
module irq_local_steer
    import irq_router_pkg::*;
#(
    parameter int N = LOCAL_N
) (
    input  logic [2*N-1:0] ctrl,
    input  logic [N-1:0]   lvl,
    output logic [N-1:0]   to_irq,
    output logic [N-1:0]   to_fiq
);
    for (genvar n = 0; n < N; n++) begin : g_src
        // fast enable has priority over normal enable
        assign to_fiq[n] = lvl[n] & ctrl[n+N];
        assign to_irq[n] = lvl[n] & ctrl[n] & ~ctrl[n+N];
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    logic       aligned;
    logic [3:0] bank;
    logic [1:0] slot;
    logic       unused_wdata;

    assign aligned      = (addr[1:0] == 2'b00);
    assign bank         = addr[7:4];
    assign slot         = addr[3:2];
    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr && aligned) begin
            if (addr == OFS_UP_ROUTE) begin
                cfg_d.up_irq_core = wdata[CORE_W-1:0];
                cfg_d.up_fiq_core = wdata[2*CORE_W-1:CORE_W];
            end else if (addr == OFS_LT_ROUTE) begin
                cfg_d.lt_core   = wdata[CORE_W-1:0];
                cfg_d.lt_as_fiq = wdata[CORE_W];
            end else if (bank == BANK_TMR) begin
                cfg_d.tmr_ctl[slot] = wdata[CTRL_W-1:0];
            end else if (bank == BANK_MBX) begin
                cfg_d.mbx_ctl[slot] = wdata[CTRL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    input  logic [NUM_CORES*LOCAL_N-1:0]  tmr_lvl,
    input  logic [NUM_CORES*LOCAL_N-1:0]  mbx_lvl,
    input  logic                          up_irq,
    input  logic                          up_fiq,
    input  logic                          lt_ie,
    input  logic                          lt_pend,
    output logic [NUM_CORES-1:0]          core_irq,
    output logic [NUM_CORES-1:0]          core_fiq
);
    cfg_t  cfg;
    stat_t st_d, st_q;

    logic [NUM_CORES-1:0][LOCAL_N-1:0] t_irq, t_fiq, m_irq, m_fiq;
    logic [NUM_CORES*SRC_W-1:0]        irq_words, fiq_words;

    irq_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        irq_local_steer #(.N(LOCAL_N)) u_tmr (
            .ctrl   (cfg.tmr_ctl[c]),
            .lvl    (tmr_lvl[c*LOCAL_N +: LOCAL_N]),
            .to_irq (t_irq[c]),
            .to_fiq (t_fiq[c])
        );
        irq_local_steer #(.N(LOCAL_N)) u_mbx (
            .ctrl   (cfg.mbx_ctl[c]),
            .lvl    (mbx_lvl[c*LOCAL_N +: LOCAL_N]),
            .to_irq (m_irq[c]),
            .to_fiq (m_fiq[c])
        );
        assign core_irq[c] = |st_q.irq_w[c];
        assign core_fiq[c] = |st_q.fiq_w[c];
    end

    // next source words from current levels and current configuration
    always_comb begin
        st_d = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            st_d.irq_w[c][BIT_TMR0 +: LOCAL_N] = t_irq[c];
            st_d.fiq_w[c][BIT_TMR0 +: LOCAL_N] = t_fiq[c];
            st_d.irq_w[c][BIT_MBX0 +: LOCAL_N] = m_irq[c];
            st_d.fiq_w[c][BIT_MBX0 +: LOCAL_N] = m_fiq[c];
        end
        if (up_irq) st_d.irq_w[cfg.up_irq_core][BIT_UP] = 1'b1;
        if (up_fiq) st_d.fiq_w[cfg.up_fiq_core][BIT_UP] = 1'b1;
        if (lt_ie && lt_pend) begin
            if (cfg.lt_as_fiq) st_d.fiq_w[cfg.lt_core][BIT_LT] = 1'b1;
            else               st_d.irq_w[cfg.lt_core][BIT_LT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_words = st_q.irq_w;
    assign fiq_words = st_q.fiq_w;

    // register read path
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[1:0] == 2'b00) begin
            if (reg_addr == OFS_UP_ROUTE) begin
                reg_rdata = DATA_W'({cfg.up_fiq_core, cfg.up_irq_core});
            end else if (reg_addr == OFS_LT_ROUTE) begin
                reg_rdata = DATA_W'({cfg.lt_as_fiq, cfg.lt_core});
            end else begin
                case (reg_addr[7:4])
                    BANK_TMR: reg_rdata = DATA_W'(cfg.tmr_ctl[reg_addr[3:2]]);
                    BANK_MBX: reg_rdata = DATA_W'(cfg.mbx_ctl[reg_addr[3:2]]);
                    BANK_IRQ: reg_rdata = DATA_W'(st_q.irq_w[reg_addr[3:2]]);
                    BANK_FIQ: reg_rdata = DATA_W'(st_q.fiq_w[reg_addr[3:2]]);
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CORES*LOCAL_N-1:0]  tmr_lvl,
    input logic [NUM_CORES*LOCAL_N-1:0]  mbx_lvl,
    input logic                          up_irq,
    input logic                          up_fiq,
    input logic                          lt_ie,
    input logic                          lt_pend,
    input logic [NUM_CORES-1:0]          core_irq,
    input logic [NUM_CORES-1:0]          core_fiq,
    input logic [NUM_CORES*SRC_W-1:0]    irq_words,
    input logic [NUM_CORES*SRC_W-1:0]    fiq_words
);
    logic                     overlap, rsv, loc_any;
    logic [NUM_CORES-1:0]     up_i, up_f;
    logic [2*NUM_CORES-1:0]   lt_vec;
    logic                     all_quiet;

    always_comb begin
        overlap = 1'b0;
        rsv     = 1'b0;
        loc_any = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            overlap   |= |(irq_words[c*SRC_W +: BIT_UP] & fiq_words[c*SRC_W +: BIT_UP]);
            rsv       |= irq_words[c*SRC_W + BIT_PERF] | irq_words[c*SRC_W + BIT_BUSCNT]
                       | fiq_words[c*SRC_W + BIT_PERF] | fiq_words[c*SRC_W + BIT_BUSCNT];
            loc_any   |= (|irq_words[c*SRC_W +: BIT_UP]) | (|fiq_words[c*SRC_W +: BIT_UP]);
            up_i[c]    = irq_words[c*SRC_W + BIT_UP];
            up_f[c]    = fiq_words[c*SRC_W + BIT_UP];
            lt_vec[c]  = irq_words[c*SRC_W + BIT_LT];
            lt_vec[NUM_CORES + c] = fiq_words[c*SRC_W + BIT_LT];
        end
    end

    assign all_quiet = (tmr_lvl == '0) && (mbx_lvl == '0) && !up_irq && !up_fiq && !(lt_ie && lt_pend);

    // R2: a local source never sits in both words of a core
    a_r2_fiq_excl: assert property (@(posedge clk) disable iff (!rst_n) !overlap);
    // R7: reserved positions stay clear
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n) !rsv);
    // R3: no local line high means no local bit next cycle
    a_r3_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_lvl == '0 && mbx_lvl == '0) |=> !loc_any);
    // R4: upstream requests land on exactly one core, and only while high
    a_r4_irq_one: assert property (@(posedge clk) disable iff (!rst_n)
        up_irq |=> $countones(up_i) == 1);
    a_r4_irq_none: assert property (@(posedge clk) disable iff (!rst_n)
        !up_irq |=> up_i == '0);
    a_r4_fiq_one: assert property (@(posedge clk) disable iff (!rst_n)
        up_fiq |=> $countones(up_f) == 1);
    a_r4_fiq_none: assert property (@(posedge clk) disable iff (!rst_n)
        !up_fiq |=> up_f == '0);
    // R5: local timer gated by enable and pending, delivered once
    a_r5_lt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_ie && lt_pend) |=> lt_vec == '0);
    a_r5_lt_one: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_ie && lt_pend) |=> $countones(lt_vec) == 1);
    // R7, R8: with every source low, all outputs drop one cycle later
    a_r7_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        all_quiet |=> (core_irq == '0 && core_fiq == '0));
endmodule

bind irq_router irq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_lvl   (tmr_lvl),
    .mbx_lvl   (mbx_lvl),
    .up_irq    (up_irq),
    .up_fiq    (up_fiq),
    .lt_ie     (lt_ie),
    .lt_pend   (lt_pend),
    .core_irq  (core_irq),
    .core_fiq  (core_fiq),
    .irq_words (irq_words),
    .fiq_words (fiq_words)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] tmr_lvl = '0;
    logic [15:0] mbx_lvl = '0;
    logic        up_irq = 1'b0, up_fiq = 1'b0, lt_ie = 1'b0, lt_pend = 1'b0;
    logic [3:0]  core_irq, core_fiq;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_lvl(tmr_lvl),
        .mbx_lvl(mbx_lvl), .up_irq(up_irq), .up_fiq(up_fiq), .lt_ie(lt_ie),
        .lt_pend(lt_pend), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int          m_tctl[4];
    int          m_mctl[4];
    int          m_up;
    int          m_lt;
    logic [11:0] m_irq[4];
    logic [11:0] m_fiq[4];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_tctl[c] = 0; m_mctl[c] = 0; m_irq[c] = '0; m_fiq[c] = '0;
            end
            m_up = 0; m_lt = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                m_irq[c] = '0; m_fiq[c] = '0;
                for (int n = 0; n < 4; n++) begin
                    if (tmr_lvl[4*c+n]) begin
                        if ((m_tctl[c] >> (n+4)) & 1) m_fiq[c][n] = 1'b1;
                        else if ((m_tctl[c] >> n) & 1) m_irq[c][n] = 1'b1;
                    end
                    if (mbx_lvl[4*c+n]) begin
                        if ((m_mctl[c] >> (n+4)) & 1) m_fiq[c][4+n] = 1'b1;
                        else if ((m_mctl[c] >> n) & 1) m_irq[c][4+n] = 1'b1;
                    end
                end
            end
            if (up_irq) m_irq[m_up & 3][8] = 1'b1;
            if (up_fiq) m_fiq[(m_up >> 2) & 3][8] = 1'b1;
            if (lt_ie && lt_pend) begin
                if (m_lt & 4) m_fiq[m_lt & 3][11] = 1'b1;
                else          m_irq[m_lt & 3][11] = 1'b1;
            end
            if (reg_wr && reg_addr[1:0] == 2'b00) begin
                if (reg_addr == 8'h0C)      m_up = int'(reg_wdata & 32'hF);
                else if (reg_addr == 8'h24) m_lt = int'(reg_wdata & 32'h7);
                else if (reg_addr >= 8'h40 && reg_addr < 8'h50)
                    m_tctl[(reg_addr - 8'h40) >> 2] = int'(reg_wdata & 32'hFF);
                else if (reg_addr >= 8'h50 && reg_addr < 8'h60)
                    m_mctl[(reg_addr - 8'h50) >> 2] = int'(reg_wdata & 32'hFF);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a == 8'h0C) return 32'(m_up);
        if (a == 8'h24) return 32'(m_lt);
        if (a >= 8'h40 && a < 8'h50) return 32'(m_tctl[(a - 8'h40) >> 2]);
        if (a >= 8'h50 && a < 8'h60) return 32'(m_mctl[(a - 8'h50) >> 2]);
        if (a >= 8'h60 && a < 8'h70) return 32'(m_irq[(a - 8'h60) >> 2]);
        if (a >= 8'h70 && a < 8'h80) return 32'(m_fiq[(a - 8'h70) >> 2]);
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // R7, R8: outputs compared with the model on every clock
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            logic [3:0] ei, ef;
            for (int c = 0; c < 4; c++) begin
                ei[c] = (m_irq[c] != 0);
                ef[c] = (m_fiq[c] != 0);
            end
            chk("R7 core_irq", {28'b0, core_irq}, {28'b0, ei});
            chk("R8 core_fiq", {28'b0, core_fiq}, {28'b0, ef});
        end
    end

    // called at a falling edge: read with the combinational path
    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic rd_model(input logic [7:0] a);
        reg_addr = a;
        #1;
        chk("R10 model read", reg_rdata, m_read(a));
    endtask

    // called at a falling edge, returns at the falling edge after the write
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] pick_addr();
        logic [7:0] k;
        k = 8'(($urandom % 4) * 4);
        case ($urandom % 8)
            0: return 8'h0C;
            1: return 8'h24;
            2: return 8'h40 + k;
            3: return 8'h50 + k;
            4: return 8'h60 + k;
            5: return 8'h70 + k;
            6: return 8'($urandom);
            default: return 8'h50 + k;
        endcase
    endfunction

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        // R1 reset state; R9 unknown offsets read zero
        chk("R1 core_irq", {28'b0, core_irq}, 32'h0);
        chk("R1 core_fiq", {28'b0, core_fiq}, 32'h0);
        for (int a = 0; a < 256; a += 4) rd("R1 R9 reset read", 8'(a), 32'h0);

        // R8 latency and level behaviour
        @(negedge clk);
        up_irq = 1'b1;
        #1 chk("R8 before edge", {28'b0, core_irq}, 32'h0);
        @(negedge clk);
        chk("R8 after edge", {28'b0, core_irq}, 32'h1);
        up_irq = 1'b0;
        @(negedge clk);
        chk("R8 level drop", {28'b0, core_irq}, 32'h0);

        // R6 write masking
        wr(8'h44, 32'hFFFF_FFA5); rd("R6 ctrl mask", 8'h44, 32'hA5);
        wr(8'h0C, 32'hFFFF_FFFF); rd("R6 route mask", 8'h0C, 32'hF);
        wr(8'h24, 32'hFFFF_FFFF); rd("R6 lt mask", 8'h24, 32'h7);
        wr(8'h0C, 32'h0); wr(8'h24, 32'h0);

        // R2 timer steering on core 1: src0 normal, src1 fast, src2 both->fast, src3 masked
        wr(8'h44, 32'h65);
        tmr_lvl = 16'h00F0;
        @(negedge clk);
        rd("R2 normal word", 8'h64, 32'h001);
        rd("R2 fast word", 8'h74, 32'h006);
        chk("R2 core_irq", {28'b0, core_irq}, 32'h2);
        chk("R2 core_fiq", {28'b0, core_fiq}, 32'h2);
        tmr_lvl = 16'h0080;
        @(negedge clk);
        rd("R2 masked normal", 8'h64, 32'h0);
        rd("R2 masked fast", 8'h74, 32'h0);

        // R3 mailbox steering on core 2: src3 normal, src0 fast
        wr(8'h58, 32'h18);
        mbx_lvl = 16'h0F00;
        @(negedge clk);
        rd("R3 normal word", 8'h68, 32'h080);
        rd("R3 fast word", 8'h78, 32'h010);
        mbx_lvl = 16'h0;

        // R4 upstream routing
        wr(8'h0C, 32'hE);
        up_irq = 1'b1; up_fiq = 1'b1;
        @(negedge clk);
        rd("R4 normal core2", 8'h68, 32'h100);
        rd("R4 fast core3", 8'h7C, 32'h100);
        rd("R4 fast core2", 8'h78, 32'h0);
        rd("R4 readback", 8'h0C, 32'hE);
        up_irq = 1'b0; up_fiq = 1'b0;

        // R5 local timer gating and routing
        wr(8'h24, 32'h5);
        lt_ie = 1'b1; lt_pend = 1'b0;
        @(negedge clk);
        rd("R5 not pending", 8'h74, 32'h0);
        lt_pend = 1'b1;
        @(negedge clk);
        rd("R5 fast core1", 8'h74, 32'h800);
        rd("R5 normal core1", 8'h64, 32'h0);
        lt_ie = 1'b0;
        @(negedge clk);
        rd("R5 not enabled", 8'h74, 32'h0);
        lt_ie = 1'b1;
        @(negedge clk);
        wr(8'h24, 32'h2);
        rd("R8 old route still", 8'h74, 32'h800);
        @(negedge clk);
        rd("R5 normal core2", 8'h68, 32'h800);
        rd("R5 fast core1 gone", 8'h74, 32'h0);
        lt_ie = 1'b0; lt_pend = 1'b0;

        // R9 ignored writes
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd("R9 ctrl0 kept", 8'h40, 32'h0);
        rd("R9 ctrl1 kept", 8'h44, 32'h65);
        rd("R9 route kept", 8'h0C, 32'hE);
        rd("R9 lt kept", 8'h24, 32'h2);
        rd("R9 misaligned", 8'h41, 32'h0);
        rd("R9 unknown", 8'hC0, 32'h0);
        rd("R9 status write", 8'h60, 32'h0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            tmr_lvl = 16'($urandom);
            mbx_lvl = 16'($urandom) & 16'($urandom);
            up_irq  = 1'($urandom);
            up_fiq  = 1'($urandom);
            lt_ie   = 1'($urandom);
            lt_pend = 1'($urandom);
            if ($urandom % 3 == 0) begin
                reg_wr = 1'b1; reg_addr = pick_addr(); reg_wdata = $urandom;
            end else begin
                reg_wr = 1'b0;
                rd_model(pick_addr());
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule